// File: doc/BRIEF.md
# Decoded Segment Test Register

This block lights the segments of a single seven-segment digit one at a time from five host-driven control lines. Three of the lines form a binary select code, which a 3-to-8 decoder turns into a one-hot pattern. A fourth line gates that decoder. The fifth line is a load strobe. The strobe is brought into the system clock domain, and its rising edge copies the decoded pattern into an 8-bit register. Each register bit drives one segment. Stepping the select code from 0 to 7, with one strobe per step, moves a single lit segment across the digit. This exercises every storage bit and every segment wire.

Seven register bits drive segments a to g. The eighth bit has no segment and is brought out on a spare pin. The decoder output polarity, the gate polarity and the segment drive polarity are parameters. A segment driven low to light, as on a common-anode digit, is handled by inverting the drive. An active-high clear input and the active-low asynchronous reset both put the register into the state that leaves every segment and the spare pin dark.

Top module: `seg_test_reg`

## Requirements
- R1: After the asynchronous reset (rst_ni low), every segment and the spare pin are dark. Dark means 0 with the default segment polarity and 1 when SEG_ACTIVE_LOW is set.
- R2: host_i[2:0] is the select code, host_i[3] is the decoder gate and host_i[4] is the load strobe. With the gate active (1 by default, 0 when EN_ACTIVE_HIGH is clear) and select k in 0..6, a strobe rising edge leaves exactly segment seg_o[k] lit (a = bit 0 through g = bit 6) and the spare pin dark.
- R3: With the gate active and select 7, a strobe rising edge leaves all seven segments dark and the spare pin lit.
- R4: With the gate inactive, a strobe rising edge leaves every segment and the spare pin dark.
- R5: Changes on the select or gate lines while the strobe is steady have no effect on seg_o or spare_o.
- R6: A falling edge of the strobe has no effect on the outputs. Only a rising edge loads the register.
- R7: The register takes the new value on the third rising clock edge after the strobe rises: two edges for the synchroniser and one for the register.
- R8: A high level on clear_i at a clock edge makes every segment and the spare pin dark. The clear takes precedence over a load in the same cycle.
- R9: When SEG_ACTIVE_LOW is set, seg_o and spare_o are the bitwise inverse of what the default polarity would drive for the same history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous clear of the register to the dark state, active high |
| host_i | input | 5 | Host lines: [2:0] select, [3] decoder gate, [4] load strobe |
| seg_o | output | 7 | Segment drives, bit 0 = a through bit 6 = g |
| spare_o | output | 1 | Register bit with no segment, same polarity as seg_o |

## Verification
The checks assume that the select and gate lines are stable from before the strobe rises until the register has loaded. Only the strobe passes through the synchroniser, so a select code that changes during that window could be captured half-old and half-new. The stimulus therefore sets select and gate, waits two clock cycles, raises the strobe, and changes nothing else for six cycles. The checks also assume that the strobe stays at each level for at least two clock cycles. The bench holds it for six.

// File: rtl/seg_test_pkg.sv
package seg_test_pkg;
  localparam int HOST_W     = 5;
  localparam int SEL_LSB    = 0;
  localparam int SEL_W      = 3;
  localparam int GATE_BIT   = 3;
  localparam int STROBE_BIT = 4;
  localparam int NUM_SEG    = 7;
endpackage

// File: rtl/seg_sync.sv
module seg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= {q[STAGES-1:0], async_i};
  end

  // q[STAGES] holds the previous synchronised level
  assign rise_o = q[STAGES-1] & ~q[STAGES];
endmodule

// File: rtl/seg_decoder.sv
module seg_decoder #(
  parameter int SEL_W          = 3,
  parameter bit OUT_ACTIVE_HIGH = 1'b1,
  parameter bit EN_ACTIVE_HIGH  = 1'b1,
  localparam int N_OUT         = 1 << SEL_W
) (
  input  logic [SEL_W-1:0] sel_i,
  input  logic             en_i,
  output logic [N_OUT-1:0] dec_o
);
  logic [N_OUT-1:0] hot;

  always_comb begin
    hot = '0;
    if (en_i == EN_ACTIVE_HIGH) hot[sel_i] = 1'b1;
  end

  generate
    if (OUT_ACTIVE_HIGH) begin : g_pos
      assign dec_o = hot;
    end else begin : g_neg
      assign dec_o = ~hot;
    end
  endgenerate
endmodule

// File: rtl/seg_latch_reg.sv
module seg_latch_reg #(
  parameter int           W       = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_o <= RST_VAL;
    else if (clear_i) q_o <= RST_VAL;
    else if (load_i)  q_o <= d_i;
  end
endmodule

// File: rtl/seg_test_reg.sv
module seg_test_reg
  import seg_test_pkg::*;
#(
  parameter bit DEC_ACTIVE_HIGH = 1'b1,
  parameter bit EN_ACTIVE_HIGH  = 1'b1,
  parameter bit SEG_ACTIVE_LOW  = 1'b0,
  parameter int SYNC_STAGES     = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic [HOST_W-1:0] host_i,
  output logic [NUM_SEG-1:0] seg_o,
  output logic              spare_o
);
  localparam int N_OUT = 1 << SEL_W;
  localparam logic [N_OUT-1:0] IDLE_VAL = DEC_ACTIVE_HIGH ? '0 : '1;

  logic             load_w;
  logic [N_OUT-1:0] dec_w;
  logic [N_OUT-1:0] latch_q;
  logic [N_OUT-1:0] lit_w;

  seg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(host_i[STROBE_BIT]),
    .rise_o (load_w)
  );

  seg_decoder #(
    .SEL_W          (SEL_W),
    .OUT_ACTIVE_HIGH(DEC_ACTIVE_HIGH),
    .EN_ACTIVE_HIGH (EN_ACTIVE_HIGH)
  ) u_dec (
    .sel_i(host_i[SEL_LSB +: SEL_W]),
    .en_i (host_i[GATE_BIT]),
    .dec_o(dec_w)
  );

  seg_latch_reg #(.W(N_OUT), .RST_VAL(IDLE_VAL)) u_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(clear_i),
    .load_i (load_w),
    .d_i    (dec_w),
    .q_o    (latch_q)
  );

  // lit_w: 1 where a segment should glow, whatever the decoder polarity
  generate
    for (genvar k = 0; k < N_OUT; k++) begin : g_lit
      assign lit_w[k] = DEC_ACTIVE_HIGH ? latch_q[k] : ~latch_q[k];
    end
    for (genvar k = 0; k < NUM_SEG; k++) begin : g_seg
      assign seg_o[k] = SEG_ACTIVE_LOW ? ~lit_w[k] : lit_w[k];
    end
  endgenerate

  assign spare_o = SEG_ACTIVE_LOW ? ~lit_w[NUM_SEG] : lit_w[NUM_SEG];
endmodule

// File: rtl/seg_test_reg_chk.sv
module seg_test_reg_chk
  import seg_test_pkg::*;
#(
  parameter bit DEC_ACTIVE_HIGH = 1'b1,
  parameter bit EN_ACTIVE_HIGH  = 1'b1,
  parameter bit SEG_ACTIVE_LOW  = 1'b0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              clear_i,
  input logic [HOST_W-1:0] host_i,
  input logic              load_w,
  input logic [7:0]        dec_w,
  input logic [7:0]        latch_q,
  input logic [NUM_SEG-1:0] seg_o,
  input logic              spare_o
);
  logic [7:0] dec_hot;
  logic [7:0] glow;
  logic       gate_on;
  assign dec_hot = DEC_ACTIVE_HIGH ? dec_w : ~dec_w;
  assign glow    = SEG_ACTIVE_LOW ? ~{spare_o, seg_o} : {spare_o, seg_o};
  assign gate_on = (host_i[GATE_BIT] == EN_ACTIVE_HIGH);

  // R2 R3: the gate decides whether exactly one decoder line is active
  assert_dec_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_on |-> $countones(dec_hot) == 1);
  // R4
  assert_dec_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gate_on |-> dec_hot == '0);
  // R5 R6
  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_w && !clear_i) |=> $stable({spare_o, seg_o}));
  // R7
  assert_capture_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_w && !clear_i) |=> latch_q == $past(dec_w));
  // R8
  assert_clear_dark_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> glow == '0);
  // R2: never more than one glowing output
  assert_single_lit_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(glow) <= 1);
endmodule

bind seg_test_reg seg_test_reg_chk #(
  .DEC_ACTIVE_HIGH(DEC_ACTIVE_HIGH),
  .EN_ACTIVE_HIGH (EN_ACTIVE_HIGH),
  .SEG_ACTIVE_LOW (SEG_ACTIVE_LOW)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .clear_i(clear_i),
  .host_i (host_i),
  .load_w (load_w),
  .dec_w  (dec_w),
  .latch_q(latch_q),
  .seg_o  (seg_o),
  .spare_o(spare_o)
);

// File: tb/seg_test_reg_test.sv
module seg_test_reg_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clear = 1'b0;
  logic [2:0] sel = '0;
  logic       en = 1'b0;
  logic       stb = 1'b0;
  logic [6:0] seg_a, seg_b;
  logic       spare_a, spare_b;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  // uut: default polarity; uut_inv: active-low decoder, gate and segments
  seg_test_reg uut (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(clear),
    .host_i({stb, en, sel}), .seg_o(seg_a), .spare_o(spare_a)
  );
  seg_test_reg #(.DEC_ACTIVE_HIGH(1'b0), .EN_ACTIVE_HIGH(1'b0), .SEG_ACTIVE_LOW(1'b1)) uut_inv (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(clear),
    .host_i({stb, ~en, sel}), .seg_o(seg_b), .spare_o(spare_b)
  );

  logic [7:0] model;

  task automatic chk(input string req);
    total++;
    if ({spare_a, seg_a} !== model) begin
      bad++;
      $display("FAIL %s default: got %b exp %b", req, {spare_a, seg_a}, model);
    end
    total++;
    if ({spare_b, seg_b} !== ~model) begin
      bad++;
      $display("FAIL %s R9 inverted: got %b exp %b", req, {spare_b, seg_b}, ~model);
    end
  endtask

  task automatic step(input logic [2:0] s, input logic e);
    @(negedge clk); sel = s; en = e;
    repeat (2) @(negedge clk);
    stb = 1'b1;
    // R7: unchanged after two edges, loaded after the third
    repeat (2) @(negedge clk);
    chk("R7 before load");
    @(negedge clk);
    model = e ? (8'd1 << s) : 8'd0;
    chk(e ? ((s == 3'd7) ? "R3" : "R2") : "R4");
    repeat (3) @(negedge clk);
    // R5: wiggle select and gate with the strobe held high
    sel = s + 3'd3; en = ~e;
    repeat (4) @(negedge clk);
    chk("R5 strobe high");
    stb = 1'b0;
    repeat (6) @(negedge clk);
    chk("R6 falling edge");
    sel = s + 3'd5; en = 1'b1;
    repeat (4) @(negedge clk);
    chk("R5 strobe low");
  endtask

  initial begin
    model = 8'd0;
    repeat (3) @(negedge clk);
    chk("R1");
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1");
    for (int e = 1; e >= 0; e--)
      for (int s = 0; s < 8; s++)
        step(3'(s), e[0]);
    step(3'd4, 1'b1);
    @(negedge clk); clear = 1'b1;
    @(negedge clk); clear = 1'b0;
    model = 8'd0;
    chk("R8");
    // R8: clear wins over a load landing in the same cycle
    step(3'd2, 1'b1);
    @(negedge clk); sel = 3'd6; en = 1'b1;
    repeat (2) @(negedge clk); stb = 1'b1;
    repeat (2) @(negedge clk); clear = 1'b1;
    @(negedge clk); clear = 1'b0;
    model = 8'd0;
    chk("R8 over load");
    repeat (3) @(negedge clk);
    chk("R8 over load");
    stb = 1'b0;
    repeat (4) @(negedge clk);
    // R1: asynchronous reset mid-run
    step(3'd1, 1'b1);
    rst_n = 1'b0;
    #1;
    model = 8'd0;
    chk("R1 async");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule